// File: doc/BRIEF.md
# Zero-Line Region Tag Cache

This block is a set-associative directory that keeps tags and no data. Each entry names an aligned region of consecutive cache lines and carries one bit per line in that region. A set bit says the line is known to be all zeros. When a read probe finds its region and the line's bit is set, the block answers with a zero-hit, so the requester can return a zeroed line without touching a data array or memory.

Writes keep the bitmap current. A full-line write of zeros sets the line's bit, and allocates a region entry on a miss. A partial write or a write of nonzero data clears the bit. A line invalidate clears the bit, and a region invalidate drops the whole entry. The lines of a region share one coherence state field, which a probe hit reports. Requests arrive on a single channel at up to one per cycle. An update takes effect at the clock edge that accepts it. A probe answer is registered and appears one cycle after the probe.

Top module: `zline_tag_cache`

## Requirements
- R1: After reset every entry is invalid, so every probe misses (hit 0, zero 0, state 0).
- R2: A line address splits into a line offset (low log2(LINES) bits), a set index (the next log2(SETS) bits) and a region tag (the remaining bits). All lines that share the bits above the offset use one entry, and the offset selects the line's bit in the bitmap.
- R3: rsp_valid_o is 1 exactly in the cycle after a probe is accepted, and 0 in every other cycle. rsp_hit_o and rsp_zero_o are 0 whenever rsp_valid_o is 0.
- R4: A probe that finds its region returns hit 1. It also returns zero 1 when the line's bit is set, and zero 0 when the bit is clear. A probe that does not find its region returns hit 0 and zero 0.
- R5: A zero write (op 1) sets the line's bit and sets the entry state to req_state_i. On a region miss it allocates an entry whose bitmap holds only that bit.
- R6: A data write (op 2) or a line invalidate (op 3) that finds its region clears the line's bit. If no bit remains set, the entry becomes invalid. On a region miss these ops have no effect.
- R7: A region invalidate (op 4) that finds its region clears the whole entry, and a probe in the next cycle misses.
- R8: An allocation takes the lowest-numbered invalid way of the set. If all four ways are valid, it takes the pseudo-LRU victim: root bit 0 chooses ways {0,1} and root bit 1 chooses ways {2,3}; within a pair, a clear bit picks the lower way.
- R9: A probe hit and every zero write mark the way they use as most recently used, so the tree points away from it. Misses, data writes and invalidates leave the tree unchanged.
- R10: The state field is encoded as I=0, S=1, E=2, O=3, M=4. A probe hit returns the entry's state, and a miss returns 0.
- R11: Op codes are probe=0, zero write=1, data write=2, line invalidate=3 and region invalidate=4. Codes 5 to 7, and any cycle with req_valid_i low, change no entry and no replacement state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 3 | Request opcode |
| req_addr_i | input | ADDR_W | Line address |
| req_state_i | input | 3 | Coherence state written by a zero write |
| rsp_valid_o | output | 1 | Probe answer valid |
| rsp_hit_o | output | 1 | Region found |
| rsp_zero_o | output | 1 | Line known to be all zero |
| rsp_state_o | output | 3 | Region coherence state on a hit |

## Verification
The hardest case to reach from the ports is a full set whose victim depends on the pseudo-LRU history. The bench builds it by allocating five or more regions that share a set index, with probe hits interleaved so the tree moves between allocations. It then probes every line of each candidate region to find out which region was evicted. A long run of mixed operations follows. Its addresses are confined to a few sets, so evictions, bits cleared to an empty bitmap, and hits directly after updates keep recurring. Every probe is compared against a behavioural model of the tags, bitmaps, states and tree bits that the bench keeps for itself.

// File: rtl/zlc_pkg.sv
package zlc_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic [2:0] {
    OP_PROBE      = 3'd0,
    OP_WR_ZERO    = 3'd1,
    OP_WR_DATA    = 3'd2,
    OP_INV_LINE   = 3'd3,
    OP_INV_REGION = 3'd4
  } zlc_op_e;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } moesi_e;
endpackage

// File: rtl/zlc_tag_array.sv
module zlc_tag_array
  import zlc_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 8,
  parameter int LINES = 8,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [SET_W-1:0]              rd_set_i,
  output logic [WAYS-1:0]               rd_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]    rd_tag_o,
  output logic [WAYS-1:0][LINES-1:0]    rd_bmp_o,
  output logic [WAYS-1:0][2:0]          rd_state_o,
  input  logic                          wr_en_i,
  input  logic [SET_W-1:0]              wr_set_i,
  input  logic [WAY_W-1:0]              wr_way_i,
  input  logic                          wr_valid_i,
  input  logic [TAG_W-1:0]              wr_tag_i,
  input  logic [LINES-1:0]              wr_bmp_i,
  input  logic [2:0]                    wr_state_i
);
  logic [SETS-1:0][WAYS-1:0]             valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][LINES-1:0]  bmp_q;
  logic [SETS-1:0][WAYS-1:0][2:0]        state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      bmp_q   <= '0;
      state_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_set_i][wr_way_i] <= wr_valid_i;
      tag_q[wr_set_i][wr_way_i]   <= wr_tag_i;
      bmp_q[wr_set_i][wr_way_i]   <= wr_valid_i ? wr_bmp_i : '0;
      state_q[wr_set_i][wr_way_i] <= wr_valid_i ? wr_state_i : ST_I;
    end
  end

  assign rd_valid_o = valid_q[rd_set_i];
  assign rd_tag_o   = tag_q[rd_set_i];
  assign rd_bmp_o   = bmp_q[rd_set_i];
  assign rd_state_o = state_q[rd_set_i];
endmodule

// File: rtl/zlc_way_match.sv
module zlc_way_match
  import zlc_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           cmp_tag_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tag_i[w] == cmp_tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/zlc_plru.sv
module zlc_plru
  import zlc_pkg::*;
#(
  parameter int SETS = 64,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i
);
  // bit0: root, bit1: pair {0,1}, bit2: pair {2,3}
  logic [SETS-1:0][2:0] tree_q;
  logic [2:0]           cur;

  assign cur      = tree_q[rd_set_i];
  assign victim_o = cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tree_q <= '0;
    end else if (touch_i) begin
      if (!touch_way_i[1]) begin
        tree_q[touch_set_i][0] <= 1'b1;
        tree_q[touch_set_i][1] <= ~touch_way_i[0];
      end else begin
        tree_q[touch_set_i][0] <= 1'b0;
        tree_q[touch_set_i][2] <= ~touch_way_i[0];
      end
    end
  end
endmodule

// File: rtl/zline_tag_cache.sv
module zline_tag_cache
  import zlc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LINES  = 8,
  parameter int SETS   = 64,
  localparam int OFF_W = $clog2(LINES),
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_state_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_zero_o,
  output logic [2:0]        rsp_state_o
);
  logic [OFF_W-1:0] off;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic [LINES-1:0] bit_sel;

  assign off     = req_addr_i[OFF_W-1:0];
  assign set_idx = req_addr_i[OFF_W +: SET_W];
  assign tag     = req_addr_i[ADDR_W-1 -: TAG_W];
  assign bit_sel = LINES'(1) << off;

  logic [WAYS-1:0]             rd_valid;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0][LINES-1:0]  rd_bmp;
  logic [WAYS-1:0][2:0]        rd_state;
  logic [WAYS-1:0]             hit_vec;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way, victim, alloc_way;
  logic                        wr_en, wr_valid, touch;
  logic [WAY_W-1:0]            wr_way;
  logic [LINES-1:0]            wr_bmp, cur_bmp;
  logic [2:0]                  wr_state;
  logic                        any_free;
  logic [WAY_W-1:0]            free_way;

  zlc_tag_array #(.SETS(SETS), .TAG_W(TAG_W), .LINES(LINES)) u_array (
    .clk_i, .rst_ni,
    .rd_set_i  (set_idx),
    .rd_valid_o(rd_valid),
    .rd_tag_o  (rd_tag),
    .rd_bmp_o  (rd_bmp),
    .rd_state_o(rd_state),
    .wr_en_i   (wr_en),
    .wr_set_i  (set_idx),
    .wr_way_i  (wr_way),
    .wr_valid_i(wr_valid),
    .wr_tag_i  (tag),
    .wr_bmp_i  (wr_bmp),
    .wr_state_i(wr_state)
  );

  zlc_way_match #(.TAG_W(TAG_W)) u_match (
    .valid_i  (rd_valid),
    .tag_i    (rd_tag),
    .cmp_tag_i(tag),
    .hit_vec_o(hit_vec),
    .hit_o    (hit),
    .hit_way_o(hit_way)
  );

  zlc_plru #(.SETS(SETS)) u_plru (
    .clk_i, .rst_ni,
    .rd_set_i   (set_idx),
    .victim_o   (victim),
    .touch_i    (touch),
    .touch_set_i(set_idx),
    .touch_way_i(wr_way)
  );

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!rd_valid[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign alloc_way = any_free ? free_way : victim;
  assign cur_bmp   = rd_bmp[hit_way];

  always_comb begin
    wr_en    = 1'b0;
    wr_valid = 1'b1;
    wr_way   = hit_way;
    wr_bmp   = cur_bmp;
    wr_state = rd_state[hit_way];
    touch    = 1'b0;
    if (req_valid_i) begin
      case (req_op_i)
        OP_PROBE: touch = hit;
        OP_WR_ZERO: begin
          wr_en    = 1'b1;
          touch    = 1'b1;
          wr_state = req_state_i;
          if (hit) begin
            wr_bmp = cur_bmp | bit_sel;
          end else begin
            wr_way = alloc_way;
            wr_bmp = bit_sel;
          end
        end
        OP_WR_DATA, OP_INV_LINE: begin
          if (hit) begin
            wr_en    = 1'b1;
            wr_bmp   = cur_bmp & ~bit_sel;
            wr_valid = |(cur_bmp & ~bit_sel);
          end
        end
        OP_INV_REGION: begin
          if (hit) begin
            wr_en    = 1'b1;
            wr_valid = 1'b0;
            wr_bmp   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  logic is_probe;
  assign is_probe = req_valid_i && (req_op_i == OP_PROBE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_zero_o  <= 1'b0;
      rsp_state_o <= ST_I;
    end else begin
      rsp_valid_o <= is_probe;
      rsp_hit_o   <= is_probe && hit;
      rsp_zero_o  <= is_probe && hit && |(cur_bmp & bit_sel);
      rsp_state_o <= (is_probe && hit) ? rd_state[hit_way] : ST_I;
    end
  end

  // history of the previous request, kept for the checks below
  logic              prev_valid;
  logic [2:0]        prev_op;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_valid <= 1'b0;
      prev_op    <= '0;
      prev_addr  <= '0;
    end else begin
      prev_valid <= req_valid_i;
      prev_op    <= req_op_i;
      prev_addr  <= req_addr_i;
    end
  end

  assert_one_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  assert_rsp_after_probe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_probe |=> rsp_valid_o);

  assert_no_rsp_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_probe |=> !rsp_valid_o);

  assert_quiet_when_invalid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_hit_o && !rsp_zero_o));

  assert_zero_needs_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_zero_o |-> rsp_hit_o);

  assert_zero_write_visible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_probe && prev_valid && prev_op == OP_WR_ZERO && prev_addr == req_addr_i)
    |=> (rsp_hit_o && rsp_zero_o));

  assert_clear_visible_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_probe && prev_valid && (prev_op == OP_WR_DATA || prev_op == OP_INV_LINE)
     && prev_addr == req_addr_i) |=> !rsp_zero_o);

  assert_region_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_probe && prev_valid && prev_op == OP_INV_REGION
     && prev_addr[ADDR_W-1:OFF_W] == req_addr_i[ADDR_W-1:OFF_W]) |=> !rsp_hit_o);
endmodule

// File: tb/zline_tag_cache_bench.sv
module zline_tag_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int LINES  = 8;
  localparam int SETS   = 4;
  localparam int OFF_W  = 3;
  localparam int SET_W  = 2;
  localparam int NREG   = 1 << (ADDR_W - OFF_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0] req_state = '0;
  logic rsp_valid, rsp_hit, rsp_zero;
  logic [2:0] rsp_state;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  zline_tag_cache #(.ADDR_W(ADDR_W), .LINES(LINES), .SETS(SETS)) u_zline_tag_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_state_i(req_state),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_zero_o(rsp_zero),
    .rsp_state_o(rsp_state)
  );

  // reference model
  bit       m_v [SETS][4];
  int       m_t [SETS][4];
  bit [7:0] m_b [SETS][4];
  bit [2:0] m_s [SETS][4];
  bit [2:0] m_p [SETS];

  function automatic void m_touch(int s, int w);
    if (w < 2) begin m_p[s][0] = 1; m_p[s][1] = (w == 0); end
    else       begin m_p[s][0] = 0; m_p[s][2] = (w == 2); end
  endfunction

  function automatic int m_find(int s, int t);
    for (int w = 0; w < 4; w++) if (m_v[s][w] && m_t[s][w] == t) return w;
    return -1;
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic issue(string rq, bit vld, int op, int addr, int st);
    int s, t, o, w, vw;
    bit eh, ez; bit [2:0] es;
    s = (addr / LINES) % SETS;
    t = addr / (LINES * SETS);
    o = addr % LINES;
    w = m_find(s, t);
    eh = 0; ez = 0; es = 0;
    req_valid = vld; req_op = 3'(op); req_addr = ADDR_W'(addr); req_state = 3'(st);
    if (vld) begin
      case (op)
        0: if (w >= 0) begin eh = 1; ez = m_b[s][w][o]; es = m_s[s][w]; m_touch(s, w); end
        1: begin
          if (w < 0) begin
            vw = -1;
            for (int k = 3; k >= 0; k--) if (!m_v[s][k]) vw = k;
            if (vw < 0) vw = m_p[s][0] ? (2 + m_p[s][2]) : m_p[s][1];
            w = vw; m_v[s][w] = 1; m_t[s][w] = t; m_b[s][w] = 0;
          end
          m_b[s][w][o] = 1; m_s[s][w] = 3'(st); m_touch(s, w);
        end
        2, 3: if (w >= 0) begin
          m_b[s][w][o] = 0;
          if (m_b[s][w] == 0) m_v[s][w] = 0;
        end
        4: if (w >= 0) begin m_v[s][w] = 0; m_b[s][w] = 0; end
        default: ;
      endcase
    end
    @(negedge clk);
    checks++;
    if (vld && op == 0) begin
      if (rsp_valid !== 1 || rsp_hit !== eh || rsp_zero !== ez || rsp_state !== es) begin
        errors++;
        $display("FAIL %s addr %0d: v/h/z/s %b%b%b/%0d expected 1%b%b/%0d",
                 rq, addr, rsp_valid, rsp_hit, rsp_zero, rsp_state, eh, ez, es);
      end
    end else if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_zero !== 0) begin
      errors++;
      $display("FAIL R3 non-probe addr %0d: v/h/z %b%b%b expected 000",
               addr, rsp_valid, rsp_hit, rsp_zero);
    end
  endtask

  task automatic probe_range(string rq, int lo, int hi);
    for (int a = lo; a <= hi; a++) issue(rq, 1, 0, a, 0);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_p[s] = 0;
      for (int w = 0; w < 4; w++) begin m_v[s][w] = 0; m_b[s][w] = 0; m_t[s][w] = 0; m_s[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every line misses after reset
    probe_range("R1", 0, (1 << ADDR_W) - 1);

    // R2 R5 R10: zero-write all lines of regions 0..5 with varied states
    for (int r = 0; r < 6; r++)
      for (int l = 0; l < LINES; l++) issue("R5", 1, 1, r * LINES + l, r % 5);
    probe_range("R2", 0, 8 * LINES - 1);

    // R4 R6: clear odd lines by data write and line invalidate
    for (int r = 0; r < 6; r++)
      for (int l = 1; l < LINES; l += 2) issue("R6", 1, (l % 4 == 1) ? 2 : 3, r * LINES + l, 0);
    probe_range("R4", 0, 8 * LINES - 1);

    // R6: clearing the last bit drops the entry
    for (int l = 0; l < LINES; l += 2) issue("R6", 1, 2, 2 * LINES + l, 0);
    probe_range("R6", 2 * LINES, 3 * LINES - 1);

    // R7: region invalidate then immediate probe
    issue("R7", 1, 4, 3 * LINES + 5, 0);
    issue("R7", 1, 0, 3 * LINES, 0);
    probe_range("R7", 3 * LINES, 4 * LINES - 1);

    // R8 R9: crowd set 1 with regions 1,5,9,13,17,21 and touch between
    for (int k = 0; k < 6; k++) begin
      issue("R8", 1, 1, (1 + 4 * k) * LINES + k, 4);
      issue("R9", 1, 0, (1 + 4 * (k / 2)) * LINES + (k / 2), 0);
      for (int j = 0; j <= k; j++) issue("R8", 1, 0, (1 + 4 * j) * LINES + j, 0);
    end
    for (int j = 0; j < 6; j++) probe_range("R8", (1 + 4 * j) * LINES, (2 + 4 * j) * LINES - 1);

    // R11: unused opcodes and idle cycles change nothing
    for (int a = 0; a < 64; a++) begin
      issue("R11", 1, 5 + (a % 3), a, 1);
      issue("R11", 0, a % 5, a, 2);
    end
    probe_range("R11", 0, 8 * LINES - 1);
    probe_range("R11", 0, NREG * LINES / 8 - 1);

    // R9 R10 R5 R6 R7: long mixed run on few sets
    for (int i = 0; i < 20000; i++) begin
      int op, a, p;
      p = $urandom_range(0, 99);
      op = (p < 40) ? 0 : (p < 70) ? 1 : (p < 82) ? 2 : (p < 92) ? 3 : (p < 96) ? 4 : 5 + (p % 3);
      a = $urandom_range(0, 255);
      issue("R9", 1, op, a, $urandom_range(0, 4));
    end
    probe_range("R9", 0, 255);

    req_valid = 1'b0;
    finish_run();
  end
endmodule